// File: doc/BRIEF.md
# Multi-Mode Configurable I/O Port

This block is an 8-bit port that extends a small host processor's own I/O. Every pin chooses, bit by bit, where its output comes from: a host-written data register, an output cell of an external logic array, a latched copy of the host address bus, or a JTAG override. The host sees four registers through a small memory-mapped bus with address, write strobe, read strobe and data buses. It writes data, direction and mode, and it reads the synchronised pin states back.

Which pins belong to the logic array and which pins JTAG may take over are fixed when the port is built, through parameters. For the remaining pins, the mode register selects host I/O or address output at run time. One parameter removes the mode register entirely, and the port then stays in host I/O mode. For pins under host or logic control, the output enable is the direction bit ORed with the logic array's product-term enable.

Top module: `cfg_io_port`

## Requirements
- R1: After reset, the data-out, direction and mode registers read 0, and every host-mode pin has pin_oe low while its pt_oe is low.
- R2: On a host-mode pin (mode bit 0, not a logic pin, no JTAG override), pin_out equals that pin's data-out register bit.
- R3: On host-mode pins and logic pins, pin_oe equals the direction bit (1 = output) ORed with the pin's pt_oe input.
- R4: A read of offset 0 returns pin_in passed through two flops. A change of pin_in driven before clock edge k is visible from edge k+1, and it is not visible after edge k alone. This holds in every pin mode.
- R5: On a pin set in the LOGIC_PINS parameter, pin_out equals lgc_out, whatever that pin's mode bit is.
- R6: On a pin that is not a logic pin and has mode bit 1, pin_out is the latched address bit and pin_oe is 1. The latch captures addr_bus on every clock edge at which ale is high and holds its value otherwise.
- R7: While jtag_en is high, every pin set in JTAG_PINS takes pin_out from jtag_out and pin_oe from jtag_oe, overriding all registers and logic inputs.
- R8: With HAS_MODE_REG = 0, the mode register reads 0, writes to it have no effect, and every non-logic pin behaves as a host-mode pin.
- R9: The register offsets are 0 data-in (read only), 1 data-out, 2 direction and 3 mode. A write lands on the clock edge at which bus_wr is sampled, and it drives the pins from that edge on. A write to offset 0 changes nothing.
- R10: bus_rdata is 0 whenever bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, combinational, 0 when not reading |
| ale | input | 1 | Address latch enable |
| addr_bus | input | W | Host address bits to latch |
| lgc_out | input | W | Logic-array output cell values |
| pt_oe | input | W | Product-term output enables |
| jtag_en | input | 1 | JTAG override enable |
| jtag_out | input | W | JTAG output values |
| jtag_oe | input | W | JTAG output enables |
| pin_in | input | W | Pad input values |
| pin_out | output | W | Pad output values |
| pin_oe | output | W | Pad output enables |

## Verification
The pin outputs depend combinationally on the registers and the live inputs. A register write or an ale pulse therefore shows on the pins after the single edge that samples the strobe. The bench drives strobes at a falling edge and checks at the next falling edge. Changes to lgc_out, pt_oe and the JTAG inputs are checked in the same half-cycle, one nanosecond after they are driven. The data-in path is due two edges after a pin change. The bench reads it after one edge and expects the old value, then after the second edge and expects the new value.

// File: rtl/cfg_io_pkg.sv
`timescale 1ns/1ps
package cfg_io_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] OFF_DIN  = 2'd0;
  localparam logic [REG_AW-1:0] OFF_DOUT = 2'd1;
  localparam logic [REG_AW-1:0] OFF_DIR  = 2'd2;
  localparam logic [REG_AW-1:0] OFF_MODE = 2'd3;

  typedef struct packed {
    logic o;
    logic oe;
  } pin_drv_t;

  // Per-pin source selection, priority JTAG > logic > address > host.
  function automatic pin_drv_t pick_pin(
    input logic is_jtag, input logic is_logic, input logic mode,
    input logic dout, input logic dir, input logic pt,
    input logic abit, input logic lgc, input logic jo, input logic joe);
    pin_drv_t r;
    if (is_jtag) begin
      r.o = jo;  r.oe = joe;
    end else if (is_logic) begin
      r.o = lgc; r.oe = dir | pt;
    end else if (mode) begin
      r.o = abit; r.oe = 1'b1;
    end else begin
      r.o = dout; r.oe = dir | pt;
    end
    return r;
  endfunction
endpackage

// File: rtl/cfg_io_sync.sv
`timescale 1ns/1ps
module cfg_io_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;
  logic [1:0]   age_q;   // cycles since reset, saturating, for checks

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      age_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  assign q = s2_q;

  a_r4_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/cfg_io_regs.sv
`timescale 1ns/1ps
module cfg_io_regs
  import cfg_io_pkg::*;
#(
  parameter int W = 8,
  parameter bit HAS_MODE_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      din_sync,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      dout_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      mode_q
);
  logic wr_dout, wr_dir, wr_mode;
  assign wr_dout = wr && (addr == OFF_DOUT);
  assign wr_dir  = wr && (addr == OFF_DIR);
  assign wr_mode = wr && (addr == OFF_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_dout) dout_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
    end
  end

  generate
    if (HAS_MODE_REG) begin : g_mode
      logic [W-1:0] mode_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_r <= '0;
        else if (wr_mode) mode_r <= wdata;
      end
      assign mode_q = mode_r;
    end else begin : g_nomode
      assign mode_q = '0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        OFF_DIN:  rdata = din_sync;
        OFF_DOUT: rdata = dout_q;
        OFF_DIR:  rdata = dir_q;
        default:  rdata = mode_q;
      endcase
    end
  end

  a_r9_dout_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dout |=> (dout_q == $past(wdata)));
  a_r9_dir_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));
  a_r8_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_MODE_REG && wr_mode) |=> (mode_q == '0));
endmodule

// File: rtl/cfg_io_pinmux.sv
`timescale 1ns/1ps
module cfg_io_pinmux
  import cfg_io_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] LOGIC_PINS = '0,
  parameter logic [W-1:0] JTAG_PINS  = '0
) (
  input  logic [W-1:0] dout,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] addr_q,
  input  logic [W-1:0] lgc_out,
  input  logic [W-1:0] pt_oe,
  input  logic         jtag_en,
  input  logic [W-1:0] jtag_out,
  input  logic [W-1:0] jtag_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    pin_drv_t drv;
    assign drv = pick_pin(jtag_en && JTAG_PINS[i], LOGIC_PINS[i], mode[i],
                          dout[i], dir[i], pt_oe[i], addr_q[i], lgc_out[i],
                          jtag_out[i], jtag_oe[i]);
    assign pin_out[i] = drv.o;
    assign pin_oe[i]  = drv.oe;
  end
endmodule

// File: rtl/cfg_io_port.sv
`timescale 1ns/1ps
module cfg_io_port
  import cfg_io_pkg::*;
#(
  parameter int W = 8,
  parameter bit HAS_MODE_REG = 1'b1,
  parameter logic [W-1:0] LOGIC_PINS = 8'hC0,
  parameter logic [W-1:0] JTAG_PINS  = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              ale,
  input  logic [W-1:0]      addr_bus,
  input  logic [W-1:0]      lgc_out,
  input  logic [W-1:0]      pt_oe,
  input  logic              jtag_en,
  input  logic [W-1:0]      jtag_out,
  input  logic [W-1:0]      jtag_oe,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe
);
  logic [W-1:0] din_sync, dout_q, dir_q, mode_q, addr_q;
  logic [W-1:0] jtag_mask, addr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr_q <= '0;
    else if (ale) addr_q <= addr_bus;
  end

  cfg_io_sync #(.W(W)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din_sync));

  cfg_io_regs #(.W(W), .HAS_MODE_REG(HAS_MODE_REG)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .din_sync(din_sync), .rdata(bus_rdata),
    .dout_q(dout_q), .dir_q(dir_q), .mode_q(mode_q));

  cfg_io_pinmux #(.W(W), .LOGIC_PINS(LOGIC_PINS), .JTAG_PINS(JTAG_PINS)) mux_i (
    .dout(dout_q), .dir(dir_q), .mode(mode_q), .addr_q(addr_q),
    .lgc_out(lgc_out), .pt_oe(pt_oe), .jtag_en(jtag_en),
    .jtag_out(jtag_out), .jtag_oe(jtag_oe),
    .pin_out(pin_out), .pin_oe(pin_oe));

  // Named views of the override and address-drive pin sets for the checks.
  assign jtag_mask = jtag_en ? JTAG_PINS : '0;
  assign addr_mask = mode_q & ~LOGIC_PINS & ~jtag_mask;

  a_r7_jtag_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & jtag_mask) == (jtag_out & jtag_mask)) &&
    ((pin_oe & jtag_mask) == (jtag_oe & jtag_mask)));
  a_r6_addr_drives: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & addr_mask) == addr_mask) &&
    ((pin_out & addr_mask) == (addr_q & addr_mask)));
  a_r6_latch_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (addr_q == $past(addr_bus)));
  a_r5_logic_source: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & LOGIC_PINS & ~jtag_mask) == (lgc_out & LOGIC_PINS & ~jtag_mask)));
endmodule

// File: tb/cfg_io_port_tb_top.sv
`timescale 1ns/1ps
module cfg_io_port_tb_top;
  localparam int W = 8;
  localparam logic [W-1:0] LP = 8'hC0;
  localparam logic [W-1:0] JP = 8'h0C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, ale = 1'b0, jtag_en = 1'b0;
  logic [W-1:0] bus_wdata = '0, addr_bus = '0, lgc_out = '0, pt_oe = '0;
  logic [W-1:0] jtag_out = '0, jtag_oe = '0, pin_in = '0;
  logic [W-1:0] rdata, pout, poe, rdata_n, pout_n, poe_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [W-1:0] m_dout = '0, m_dir = '0, m_mode = '0, m_addr = '0;

  always #2 clk = ~clk;

  cfg_io_port #(.W(W), .HAS_MODE_REG(1'b1), .LOGIC_PINS(LP), .JTAG_PINS(JP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .ale(ale), .addr_bus(addr_bus),
    .lgc_out(lgc_out), .pt_oe(pt_oe), .jtag_en(jtag_en), .jtag_out(jtag_out),
    .jtag_oe(jtag_oe), .pin_in(pin_in), .pin_out(pout), .pin_oe(poe));

  cfg_io_port #(.W(W), .HAS_MODE_REG(1'b0), .LOGIC_PINS(LP), .JTAG_PINS(JP)) dut_nm_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_n), .ale(ale), .addr_bus(addr_bus),
    .lgc_out(lgc_out), .pt_oe(pt_oe), .jtag_en(jtag_en), .jtag_out(jtag_out),
    .jtag_oe(jtag_oe), .pin_in(pin_in), .pin_out(pout_n), .pin_oe(poe_n));

  // Expected pins, built from pin sets rather than per-bit priority.
  function automatic logic [W-1:0] exp_out(input logic [W-1:0] md);
    logic [W-1:0] jm, lm, am, hm;
    jm = jtag_en ? JP : '0;
    lm = LP & ~jm;
    am = md & ~LP & ~jm;
    hm = ~(jm | lm | am);
    return (jtag_out & jm) | (lgc_out & lm) | (m_addr & am) | (m_dout & hm);
  endfunction
  function automatic logic [W-1:0] exp_oe(input logic [W-1:0] md);
    logic [W-1:0] jm, am;
    jm = jtag_en ? JP : '0;
    am = md & ~LP & ~jm;
    return (jtag_oe & jm) | am | ((m_dir | pt_oe) & ~jm & ~am);
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_pins(input string tag);
    check({tag, " pin_out"}, pout, exp_out(m_mode));
    check({tag, " pin_oe"}, poe, exp_oe(m_mode));
    check({tag, " R8 nomode pin_out"}, pout_n, exp_out('0));
    check({tag, " R8 nomode pin_oe"}, poe_n, exp_oe('0));
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      2'd1: m_dout = d;
      2'd2: m_dir = d;
      2'd3: m_mode = d;
      default: ;
    endcase
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [W-1:0] v, output logic [W-1:0] vn);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    v = rdata; vn = rdata_n;
    bus_rd = 1'b0;
  endtask

  task automatic latch_addr(input logic [W-1:0] v);
    @(negedge clk);
    addr_bus = v; ale = 1'b1;
    @(negedge clk);
    ale = 1'b0; addr_bus = ~v;
    m_addr = v;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v, vn;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(2'd1, v, vn); check("R1 dout reset", v, '0);
    rd_reg(2'd2, v, vn); check("R1 dir reset", v, '0);
    rd_reg(2'd3, v, vn); check("R1 mode reset", v, '0);
    check("R1 oe reset", poe & ~LP, '0);

    // R2/R3/R9 host mode output
    wr_reg(2'd1, 8'hA5);
    wr_reg(2'd2, 8'hFF);
    check("R2 dout drives", pout & ~LP & ~JP, 8'hA5 & ~LP & ~JP);
    check("R3 dir drives oe", poe, 8'hFF);
    rd_reg(2'd1, v, vn); check("R9 dout readback", v, 8'hA5);
    wr_reg(2'd2, 8'h00);
    pt_oe = 8'h4B; #1;
    check("R3 pt_oe or", poe, 8'h4B);
    check_pins("R3");

    // R5 logic pins ignore mode
    wr_reg(2'd3, 8'hFF);
    lgc_out = 8'h80; #1;
    check("R5 logic out", pout & LP, 8'h80);
    check_pins("R5");

    // R6 address latch
    latch_addr(8'h5A);
    check("R6 addr out", pout & ~LP, 8'h5A & ~LP);
    check("R6 addr oe", poe & ~LP, ~LP);
    @(negedge clk);
    check("R6 latch holds", pout & ~LP, 8'h5A & ~LP);
    check_pins("R6");

    // R7 JTAG override
    jtag_en = 1'b1; jtag_out = 8'h04; jtag_oe = 8'h08; #1;
    check("R7 jtag out", pout & JP, 8'h04);
    check("R7 jtag oe", poe & JP, 8'h08);
    check_pins("R7");
    jtag_en = 1'b0;

    // R9 write to offset 0 ignored
    wr_reg(2'd0, 8'h3C);
    rd_reg(2'd1, v, vn); check("R9 off0 dout kept", v, 8'hA5);
    rd_reg(2'd2, v, vn); check("R9 off0 dir kept", v, 8'h00);
    rd_reg(2'd3, v, vn); check("R9 off0 mode kept", v, 8'hFF);
    check_pins("R9");

    // R8 mode register absent
    rd_reg(2'd3, v, vn); check("R8 nomode reads 0", vn, '0);

    // R10 idle read bus
    bus_addr = 2'd1; #1;
    check("R10 rdata idle", rdata, '0);

    // R4 synchronizer latency, pins in address mode
    @(negedge clk); pin_in = 8'hE7;
    @(negedge clk);
    rd_reg(2'd0, v, vn); check("R4 not after one edge", v, 8'h00);
    @(negedge clk);
    rd_reg(2'd0, v, vn); check("R4 after two edges", v, 8'hE7);
    check("R4 nomode din", vn, 8'hE7);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 4);
      if (op < 3) wr_reg(2'($urandom_range(0, 3)), W'($urandom));
      else if (op == 3) latch_addr(W'($urandom));
      else begin
        logic [W-1:0] pv;
        pv = W'($urandom);
        @(negedge clk); pin_in = pv;
        repeat (2) @(negedge clk);
        rd_reg(2'd0, v, vn); check("R4 random din", v, pv);
      end
      @(negedge clk);
      lgc_out = W'($urandom); pt_oe = W'($urandom);
      jtag_en = ($urandom_range(0, 3) == 0);
      jtag_out = W'($urandom); jtag_oe = W'($urandom);
      #1;
      check_pins("R2 R3 R5 R6 R7 random");
      rd_reg(2'd3, v, vn);
      check("R9 random mode", v, m_mode);
      check("R8 random nomode", vn, '0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule